// File: doc/BRIEF.md
# I2C Quick-Command Bit Sequencer

This block runs a complete zero-length I2C transaction by driving the SCL and SDA lines itself. The sequence is a START, a single address byte that carries the read/write flag, one acknowledge sample and a STOP. Byte-oriented controllers often cannot issue a transaction with no data phase. Software uses this sequencer when it wants to probe whether a target answers at a given 7-bit address.

A one-cycle start strobe captures the address, the read/write flag and the speed select (standard or fast). Each bus phase is timed by counting system clocks against the nanosecond minimum for the selected speed. Every count is rounded up, so a minimum is never cut short. Each time the block releases SCL, it waits for the line to read high. This allows a target to stretch the clock. The wait is bounded by a cycle limit, and a line that stays low past that limit ends the transaction with a stuck-bus result.

The outputs are open-drain enables: a 1 means the line is driven low, and a 0 means the line is released. At the end of a transaction the block pulses done and reports either ACK/NACK or a stuck bus.

Top module: `iqc_quick_seq`

## Requirements
- R1: Phase lengths in clock cycles are ceil(t/CLK_PERIOD_NS) for these minimums:
  - standard mode: start hold 4000 ns, stop setup 4000 ns, SCL low 4700 ns, SCL high 4000 ns, bus free 4700 ns;
  - fast mode: 600, 600, 1300, 600 and 1300 ns for the same five phases.
  - Each half of a bit's low time lasts ceil(low/(2*CLK_PERIOD_NS)) cycles.
- R2: start_i is accepted only while the block is idle, and address, rd_i and fast_i are captured at that moment. A strobe or input change during a transaction has no effect on the waveform or the result.
- R3: The first cycle after an accepted strobe releases both lines and waits until both read high. Then one bus-free period follows with both lines still released.
- R4: START: SDA is driven low while SCL stays released, for the start-hold time.
- R5: The byte {addr_i, rd_i} goes out MSB first, one bit per clock, in this order:
  - SCL low for half the low time with SDA unchanged;
  - the new SDA level for the other half;
  - SCL released, then a wait until SCL reads high;
  - the high time.
- R6: On the ninth clock SDA is released. SDA is sampled on the cycle in which SCL is first seen high, and a high level gives nack_o=1.
- R7: STOP:
  - both lines driven low for the full low time;
  - SCL released and waited for high;
  - stop setup time;
  - SDA released, then one bus-free period.
- R8: A target holding SCL low after release stretches the wait. The high-time count starts only once SCL reads high.
- R9: The block waits at most TIMEOUT_CYC cycles for the lines to read high. If a line is still low after that, the transaction ends with stuck_o=1 and nack_o=0, and both lines are released.
- R10: done_o is a single-cycle pulse on the cycle after the last phase. nack_o and stuck_o are valid with done_o and hold until the next accepted strobe. Outside a transaction both lines are released.
- R11: During and right after reset both lines are released and done_o, nack_o and stuck_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| addr_i | input | 7 | Target address |
| rd_i | input | 1 | Read/write flag sent as the last address bit (1 = read) |
| fast_i | input | 1 | 1 selects fast-mode timing, 0 selects standard |
| scl_in_i | input | 1 | Level sensed on SCL |
| sda_in_i | input | 1 | Level sensed on SDA |
| scl_oe_o | output | 1 | 1 drives SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 drives SDA low, 0 releases it |
| done_o | output | 1 | Completion pulse |
| nack_o | output | 1 | Target did not acknowledge |
| stuck_o | output | 1 | A line failed to rise in time |

## Verification
The first phase appears one cycle after the clock edge that samples the strobe, and every later phase follows with no gap. done_o rises one cycle after the final bus-free count, or one cycle after a wait reaches its limit. The bench builds a per-cycle list of expected line enables and results from the requirements, including stretch cycles and the acknowledge window, and compares it with the outputs mid-cycle after every edge. A separate check confirms that the total number of cycles from strobe to done matches the list length.

// File: rtl/iqc_pkg.sv
package iqc_pkg;

    // Minimum bus times in nanoseconds, per speed
    localparam int STD_HOLD_NS  = 4000;
    localparam int STD_SETUP_NS = 4000;
    localparam int STD_LOW_NS   = 4700;
    localparam int STD_HIGH_NS  = 4000;
    localparam int STD_FREE_NS  = 4700;
    localparam int FST_HOLD_NS  = 600;
    localparam int FST_SETUP_NS = 600;
    localparam int FST_LOW_NS   = 1300;
    localparam int FST_HIGH_NS  = 600;
    localparam int FST_FREE_NS  = 1300;

    // Round a time up to whole clock periods
    function automatic int ceil_cycles(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [3:0] {
        PH_IDLE, PH_FREE, PH_BUF, PH_HOLD,
        PH_LOW_A, PH_LOW_B, PH_RISE, PH_HIGH,
        PH_STOP_LOW, PH_STOP_RISE, PH_STOP_SU, PH_STOP_BUF
    } phase_e;

    typedef struct packed {
        logic [6:0] addr;
        logic       rd;
        logic       fast;
    } req_t;

endpackage

// File: rtl/iqc_timing.sv
module iqc_timing
    import iqc_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int CW            = 16
) (
    input  phase_e          phase_i,
    input  logic            fast_i,
    output logic [CW-1:0]   dur_o
);
    localparam int S_FREE  = ceil_cycles(STD_FREE_NS,  CLK_PERIOD_NS);
    localparam int S_HOLD  = ceil_cycles(STD_HOLD_NS,  CLK_PERIOD_NS);
    localparam int S_SETUP = ceil_cycles(STD_SETUP_NS, CLK_PERIOD_NS);
    localparam int S_HIGH  = ceil_cycles(STD_HIGH_NS,  CLK_PERIOD_NS);
    localparam int S_LOW   = ceil_cycles(STD_LOW_NS,   CLK_PERIOD_NS);
    localparam int S_HALF  = ceil_cycles(STD_LOW_NS,   2 * CLK_PERIOD_NS);
    localparam int F_FREE  = ceil_cycles(FST_FREE_NS,  CLK_PERIOD_NS);
    localparam int F_HOLD  = ceil_cycles(FST_HOLD_NS,  CLK_PERIOD_NS);
    localparam int F_SETUP = ceil_cycles(FST_SETUP_NS, CLK_PERIOD_NS);
    localparam int F_HIGH  = ceil_cycles(FST_HIGH_NS,  CLK_PERIOD_NS);
    localparam int F_LOW   = ceil_cycles(FST_LOW_NS,   CLK_PERIOD_NS);
    localparam int F_HALF  = ceil_cycles(FST_LOW_NS,   2 * CLK_PERIOD_NS);

    always_comb begin
        unique case (phase_i)
            PH_BUF, PH_STOP_BUF: dur_o = fast_i ? CW'(F_FREE)  : CW'(S_FREE);
            PH_HOLD:             dur_o = fast_i ? CW'(F_HOLD)  : CW'(S_HOLD);
            PH_LOW_A, PH_LOW_B:  dur_o = fast_i ? CW'(F_HALF)  : CW'(S_HALF);
            PH_HIGH:             dur_o = fast_i ? CW'(F_HIGH)  : CW'(S_HIGH);
            PH_STOP_LOW:         dur_o = fast_i ? CW'(F_LOW)   : CW'(S_LOW);
            PH_STOP_SU:          dur_o = fast_i ? CW'(F_SETUP) : CW'(S_SETUP);
            default:             dur_o = CW'(1);
        endcase
    end
endmodule

// File: rtl/iqc_counter.sv
module iqc_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_o <= '0;
        else if (inc_i)
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/iqc_shifter.sv
module iqc_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [BITS-1:0] byte_i,
    input  logic            shift_i,
    output logic            bit_o,
    output logic            last_o
);
    localparam int IW = $clog2(BITS + 1);

    logic [BITS-1:0] sh_q;
    logic [IW-1:0]   idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sh_q  <= byte_i;
            idx_q <= '0;
        end else if (shift_i) begin
            sh_q  <= {sh_q[BITS-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_o  = sh_q[BITS-1];
    assign last_o = (idx_q == IW'(BITS));
endmodule

// File: rtl/iqc_quick_seq.sv
module iqc_quick_seq
    import iqc_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int TIMEOUT_CYC   = 50000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [6:0] addr_i,
    input  logic       rd_i,
    input  logic       fast_i,
    input  logic       scl_in_i,
    input  logic       sda_in_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    output logic       done_o,
    output logic       nack_o,
    output logic       stuck_o
);
    localparam int LONGEST = max2(ceil_cycles(STD_FREE_NS, CLK_PERIOD_NS), TIMEOUT_CYC);
    localparam int CW      = $clog2(LONGEST + 1);

    phase_e        ph, ph_nxt;
    req_t          req_in;
    logic          fast_q, sda_low_q, nack_q;
    logic [CW-1:0] cnt, dur;
    logic          bit_val, bit_last;
    logic          timed_end, wait_end, finish, fail, accept, shift_go;

    assign req_in    = '{addr: addr_i, rd: rd_i, fast: fast_i};
    assign accept    = (ph == PH_IDLE) && start_i;
    assign timed_end = (cnt == dur - 1'b1);
    assign wait_end  = (cnt == CW'(TIMEOUT_CYC - 1));
    assign shift_go  = (ph == PH_HIGH) && timed_end && !bit_last;

    iqc_timing #(.CLK_PERIOD_NS(CLK_PERIOD_NS), .CW(CW)) u_timing (
        .phase_i (ph),
        .fast_i  (fast_q),
        .dur_o   (dur)
    );

    iqc_counter #(.CW(CW)) u_count (
        .clk   (clk),
        .rst   (rst),
        .clr_i (ph_nxt != ph),
        .inc_i (ph != PH_IDLE),
        .cnt_o (cnt)
    );

    iqc_shifter #(.BITS(8)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load_i  (accept),
        .byte_i  ({req_in.addr, req_in.rd}),
        .shift_i (shift_go),
        .bit_o   (bit_val),
        .last_o  (bit_last)
    );

    always_comb begin
        ph_nxt = ph;
        finish = 1'b0;
        fail   = 1'b0;
        unique case (ph)
            PH_IDLE:      if (start_i) ph_nxt = PH_FREE;
            PH_FREE:      if (scl_in_i && sda_in_i) ph_nxt = PH_BUF;
                          else if (wait_end) fail = 1'b1;
            PH_BUF:       if (timed_end) ph_nxt = PH_HOLD;
            PH_HOLD:      if (timed_end) ph_nxt = PH_LOW_A;
            PH_LOW_A:     if (timed_end) ph_nxt = PH_LOW_B;
            PH_LOW_B:     if (timed_end) ph_nxt = PH_RISE;
            PH_RISE:      if (scl_in_i) ph_nxt = PH_HIGH;
                          else if (wait_end) fail = 1'b1;
            PH_HIGH:      if (timed_end) ph_nxt = bit_last ? PH_STOP_LOW : PH_LOW_A;
            PH_STOP_LOW:  if (timed_end) ph_nxt = PH_STOP_RISE;
            PH_STOP_RISE: if (scl_in_i) ph_nxt = PH_STOP_SU;
                          else if (wait_end) fail = 1'b1;
            PH_STOP_SU:   if (timed_end) ph_nxt = PH_STOP_BUF;
            PH_STOP_BUF:  if (timed_end) begin
                              ph_nxt = PH_IDLE;
                              finish = 1'b1;
                          end
            default:      ph_nxt = PH_IDLE;
        endcase
        if (fail) begin
            ph_nxt = PH_IDLE;
            finish = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            fast_q    <= 1'b0;
            sda_low_q <= 1'b0;
            nack_q    <= 1'b0;
            done_o    <= 1'b0;
            nack_o    <= 1'b0;
            stuck_o   <= 1'b0;
        end else begin
            ph     <= ph_nxt;
            done_o <= finish;
            if (accept) begin
                fast_q  <= req_in.fast;
                nack_o  <= 1'b0;
                stuck_o <= 1'b0;
            end
            if (ph == PH_BUF && ph_nxt == PH_HOLD)
                sda_low_q <= 1'b1;
            if (ph == PH_LOW_A && ph_nxt == PH_LOW_B)
                sda_low_q <= bit_last ? 1'b0 : ~bit_val;
            if (ph == PH_RISE && scl_in_i && bit_last)
                nack_q <= sda_in_i;
            if (finish) begin
                nack_o  <= fail ? 1'b0 : nack_q;
                stuck_o <= fail;
            end
        end
    end

    always_comb begin
        scl_oe_o = (ph == PH_LOW_A) || (ph == PH_LOW_B) || (ph == PH_STOP_LOW);
        sda_oe_o = (ph == PH_HOLD) || (ph == PH_STOP_LOW) || (ph == PH_STOP_RISE) ||
                   (ph == PH_STOP_SU) ||
                   (sda_low_q && ((ph == PH_LOW_A) || (ph == PH_LOW_B) ||
                                  (ph == PH_RISE)  || (ph == PH_HIGH)));
    end

    // SDA may move while SCL is released only for START, STOP or an abort
    assert_sda_edge_scl_high_R7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe_o) && !scl_oe_o && !$past(scl_oe_o))
            |-> (ph == PH_HOLD || ph == PH_STOP_BUF || stuck_o));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_released_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!scl_oe_o && !sda_oe_o));

    assert_stuck_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(stuck_o) |-> done_o);

    assert_wait_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_FREE || ph == PH_RISE || ph == PH_STOP_RISE)
            |-> (cnt < CW'(TIMEOUT_CYC)));

    assert_busy_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_IDLE && start_i) |=> $stable(fast_q));

endmodule

// File: tb/iqc_quick_seq_tb.sv
module iqc_quick_seq_tb;
    localparam int CLK_NS = 20;
    localparam int TMO    = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [6:0] addr = '0;
    logic       rd = 1'b0;
    logic       fast = 1'b0;
    logic       scl_oe, sda_oe, done, nack, stuck;
    logic       scl_in, sda_in;
    logic       ack_pull = 1'b0;
    logic       sda_stuck = 1'b0;
    int         stretch_cfg = 0;
    int         stretch_left = 0;

    int checks = 0;
    int errors = 0;
    logic last_nack = 1'b0;
    logic last_stuck = 1'b0;

    typedef struct packed {
        logic       scl;
        logic       sda;
        logic       dn;
        logic       nk;
        logic       st;
        logic       aw;
        logic [7:0] req;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_NS / 2) clk = ~clk;

    // Target model: stretches SCL after each release, pulls SDA in the ack window
    always @(posedge clk) begin
        if (rst) stretch_left <= 0;
        else if (scl_oe) stretch_left <= stretch_cfg;
        else if (stretch_left > 0) stretch_left <= stretch_left - 1;
    end
    assign scl_in = !scl_oe && (stretch_left == 0);
    assign sda_in = !sda_oe && !ack_pull && !sda_stuck;

    iqc_quick_seq #(.CLK_PERIOD_NS(CLK_NS), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .addr_i(addr), .rd_i(rd),
        .fast_i(fast), .scl_in_i(scl_in), .sda_in_i(sda_in),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .done_o(done),
        .nack_o(nack), .stuck_o(stuck)
    );

    function automatic int cdiv(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    task automatic put(input int n, input logic s, input logic d, input logic aw, input int req);
        for (int k = 0; k < n; k++)
            exp_q.push_back('{scl: s, sda: d, dn: 1'b0, nk: 1'b0, st: 1'b0, aw: aw, req: 8'(req)});
    endtask

    task automatic put_done(input logic nk, input logic st);
        // R10: single done cycle carrying the result, lines released
        exp_q.push_back('{scl: 1'b0, sda: 1'b0, dn: 1'b1, nk: nk, st: st, aw: 1'b0, req: 8'd10});
    endtask

    task automatic check(input logic ok, input string tag, input int got, input int want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, want, $time);
        end
    endtask

    // Cycle-by-cycle comparison, mid-cycle after each rising edge
    initial begin
        exp_t e;
        logic [4:0] got, want;
        forever begin
            @(posedge clk);
            #5;
            if (rst) begin
                last_nack  = 1'b0;
                last_stuck = 1'b0;
                e = '{scl: 1'b0, sda: 1'b0, dn: 1'b0, nk: 1'b0, st: 1'b0, aw: 1'b0, req: 8'd11};
            end else if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
            end else begin
                e = '{scl: 1'b0, sda: 1'b0, dn: 1'b0, nk: last_nack, st: last_stuck, aw: 1'b0, req: 8'd10};
            end
            if (e.dn) begin
                last_nack  = e.nk;
                last_stuck = e.st;
            end
            got  = {scl_oe, sda_oe, done, nack, stuck};
            want = {e.scl, e.sda, e.dn,
                    (e.dn || e.req == 8'd10 || e.req == 8'd11) ? e.nk : nack,
                    (e.dn || e.req == 8'd10 || e.req == 8'd11) ? e.st : stuck};
            checks++;
            if (got !== want) begin
                errors++;
                $display("FAIL R%0d per-cycle {scl,sda,done,nack,stuck} actual=%b expected=%b at %0t",
                         e.req, got, want, $time);
            end
            ack_pull = e.aw;
        end
    end

    // Build the expected waveform from the requirements, then run it
    task automatic run(input logic [6:0] a, input logic r, input logic f, input logic ack,
                       input int s, input logic stuck_sda, input int inject, input string name);
        int b, hd, half, hi, lo, su, len, cycles;
        logic [7:0] byt;
        logic prev, v, aw, exp_nk, exp_st;
        // R1: ceil of each minimum over the clock period
        b    = cdiv(f ? 1300 : 4700, CLK_NS);
        hd   = cdiv(f ? 600  : 4000, CLK_NS);
        half = cdiv(f ? 1300 : 4700, 2 * CLK_NS);
        hi   = cdiv(f ? 600  : 4000, CLK_NS);
        lo   = cdiv(f ? 1300 : 4700, CLK_NS);
        su   = cdiv(f ? 600  : 4000, CLK_NS);
        exp_nk = 1'b0;
        exp_st = 1'b0;
        @(negedge clk);
        stretch_cfg = s;
        sda_stuck   = stuck_sda;
        if (stuck_sda) begin
            put(TMO, 1'b0, 1'b0, 1'b0, 9);          // R9: free wait times out
            exp_st = 1'b1;
            put_done(1'b0, 1'b1);
        end else begin
            put(1, 1'b0, 1'b0, 1'b0, 3);            // R3: lines seen high
            put(b, 1'b0, 1'b0, 1'b0, 3);            // R3: bus free
            put(hd, 1'b0, 1'b1, 1'b0, 4);           // R4: START hold
            byt  = {a, r};
            prev = 1'b1;
            for (int i = 0; i < 9; i++) begin
                v  = (i < 8) ? ~byt[7 - i] : 1'b0;
                aw = (i == 8) && ack;
                put(half, 1'b1, prev, 1'b0, 5);     // R5: first half low
                put(half, 1'b1, v, aw, (i == 8) ? 6 : 5);
                if (s >= TMO) begin
                    put(TMO, 1'b0, v, aw, 9);       // R9: SCL never rises in time
                    exp_st = 1'b1;
                    break;
                end
                put(s + 1, 1'b0, v, aw, 8);         // R8: stretched rise
                put(hi, 1'b0, v, aw, (i == 8) ? 6 : 5);
                prev = v;
            end
            if (exp_st) begin
                put_done(1'b0, 1'b1);
            end else begin
                put(lo, 1'b1, 1'b1, 1'b0, 7);       // R7: both low
                put(s + 1, 1'b0, 1'b1, 1'b0, 7);    // R7: SCL rise
                put(su, 1'b0, 1'b1, 1'b0, 7);       // R7: setup
                put(b, 1'b0, 1'b0, 1'b0, 7);        // R7: bus free after STOP
                exp_nk = ~ack;
                put_done(~ack, 1'b0);
            end
        end
        len = exp_q.size();
        addr = a; rd = r; fast = f; start = 1'b1;
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
            start = (inject > 0) && (cycles == inject);
            if (start) begin
                addr = ~a; rd = ~r; fast = ~f;       // R2: must be ignored
            end
        end while (!done && cycles < 100000);
        start = 1'b0;
        sda_stuck = 1'b0;
        stretch_cfg = 0;
        check(cycles == len, {"R1 length ", name}, cycles, len);
        check(nack == exp_nk, {"R6 nack ", name}, nack, exp_nk);
        check(stuck == exp_st, {"R9 stuck ", name}, stuck, exp_st);
        repeat (60) @(negedge clk);
        check(nack == exp_nk && stuck == exp_st && !done, {"R10 hold ", name},
              {done, nack, stuck}, {1'b0, exp_nk, exp_st});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!scl_oe && !sda_oe && !done && !nack && !stuck, "R11 reset",
              {scl_oe, sda_oe, done, nack, stuck}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        run(7'h50, 1'b0, 1'b0, 1'b1, 0,  1'b0, 0,   "std write ack");
        run(7'h2A, 1'b1, 1'b1, 1'b0, 0,  1'b0, 100, "fast read nack busy strobe");
        run(7'h7F, 1'b1, 1'b1, 1'b1, 5,  1'b0, 0,   "fast stretched");
        run(7'h00, 1'b0, 1'b1, 1'b1, 45, 1'b0, 0,   "scl held low");
        run(7'h11, 1'b0, 1'b1, 1'b1, 0,  1'b1, 0,   "sda stuck before start");
        run(7'h35, 1'b1, 1'b0, 1'b0, 3,  1'b0, 0,   "std read nack stretched");
        run(7'h6C, 1'b0, 1'b1, 1'b1, 0,  1'b0, 0,   "fast after errors");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule